// File: doc/BRIEF.md
# Periodic Timer with Watchdog

This block is a bus-clocked timer peripheral. It holds three functions that share one prescaler. An 8-bit free-running counter raises an overflow flag each time it wraps. A divider tap raises a periodic flag at a selectable rate. A watchdog counts the same periodic ticks and issues a reset pulse unless software services it in time.

Software controls the block through a single write port with two targets. The first is a control/status register, which holds the two flags, their interrupt enables and a 2-bit rate code. The second is a service strobe that restarts the watchdog. The interrupt request is the OR of each flag gated by its enable.

A single rate code sets both the periodic flag interval and the watchdog timeout. Change the code only right after a service write. The watchdog counter is restarted without regard to the phase of the prescaler, so the real timeout falls between 63 and 64 tick periods after a service.

Top module: `mft_timer_wdog`

## Requirements
- R1: After reset the status register reads 0x03 (flags clear, enables clear, rate code 11 = slowest), the counter reads 0, and the interrupt and watchdog reset outputs are low.
- R2: The counter advances by one on every 2^CNT_DIV_LOG2-th bus clock (every 4th clock by default), counted from reset.
- R3: Bit 7 (overflow flag) sets in the cycle the counter goes from 0xFF to 0x00.
- R4: Bit 6 (periodic flag) sets once every 2^(RTI_DIV_LOG2 + rate) bus clocks, where rate is the code in bits 1:0 (00 = fastest, 11 = slowest).
- R5: A write to the status register (select 0) clears a flag only when the written bit is 0. A written 1 leaves the flag unchanged. If a set and a clear happen in the same cycle, the set wins.
- R6: irq_o is high when (bit 7 AND bit 5) or (bit 6 AND bit 4). Clearing an enable blocks the request but keeps the flag.
- R7: A status register write loads bit 5 (overflow enable), bit 4 (periodic enable) and bits 1:0 (rate). Bits 3:2 always read 0.
- R8: The watchdog counts periodic ticks. On the 2^COP_W-th tick (64 by default) since its last restart, wdr_o pulses high for exactly one cycle, and in that same cycle all timer state returns to its R1 values.
- R9: A write with select 1 restarts the watchdog count. A restart that lands on a tick cycle wins over that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = status register, 1 = watchdog service |
| wr_data | input | 8 | Write data |
| csr_rd | output | 8 | Status register contents |
| cnt_rd | output | CNT_W | Free-running counter value |
| irq_o | output | 1 | Interrupt request |
| wdr_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The embedded assertions check the local cycle rules on every cycle: the counter step and hold, flag setting on overflow and on a periodic tick, a held flag surviving a write of 1, the watchdog advancing and clearing on service, and the single-cycle reset pulse with restored state. Other behaviours depend on absolute timing, and only the bench scenarios can show them. These are the exact periods for each rate code, the 64-tick timeout measured from reset and from a service, the precedence of set over clear, and the interrupt gating across sequences of enable changes.

// File: rtl/mft_pkg.sv
// Package: shared field positions, select codes and reset values for the
// periodic timer with watchdog. Assumes an 8-bit status register.
package mft_pkg;
    localparam int CSR_W      = 8;
    localparam int BIT_OVF    = 7;   // overflow flag
    localparam int BIT_PER    = 6;   // periodic flag
    localparam int BIT_OVF_EN = 5;   // overflow interrupt enable
    localparam int BIT_PER_EN = 4;   // periodic interrupt enable

    localparam logic       SEL_CSR   = 1'b0;
    localparam logic       SEL_SVC   = 1'b1;
    localparam logic [1:0] RATE_SLOW = 2'b11;

    typedef struct packed {
        logic       ovf_flag;
        logic       per_flag;
        logic       ovf_en;
        logic       per_en;
        logic [1:0] rsvd;
        logic [1:0] rate;
    } csr_t;

    localparam csr_t CSR_RESET = '{ovf_flag: 1'b0, per_flag: 1'b0,
                                   ovf_en: 1'b0, per_en: 1'b0,
                                   rsvd: 2'b00, rate: RATE_SLOW};
endpackage

// File: rtl/mft_prescaler.sv
// Prescaler: one binary divider that yields the counter step and the
// rate-selected periodic tick. Each tick is a one-cycle strobe.
// Assumes RTI_DIV_LOG2 >= CNT_DIV_LOG2 >= 1.
module mft_prescaler #(
    parameter int CNT_DIV_LOG2 = 2,
    parameter int RTI_DIV_LOG2 = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] rate,
    output logic       cnt_tick,
    output logic       rti_tick
);
    localparam int PRE_W = RTI_DIV_LOG2 + 3;

    logic [PRE_W-1:0] pre_q;
    logic [3:0]       tap;

    // Free-running divider, restarted by reset or watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else               pre_q <= pre_q + PRE_W'(1);
    end

    // One tap per rate code: all low bits set marks the last clock of a period.
    for (genvar r = 0; r < 4; r++) begin : g_tap
        assign tap[r] = &pre_q[RTI_DIV_LOG2+r-1:0];
    end

    assign rti_tick = tap[rate];
    assign cnt_tick = &pre_q[CNT_DIV_LOG2-1:0];

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_tick && !clr && $stable(rate)) |=> !rti_tick); // R4
endmodule

// File: rtl/mft_freerun.sv
// Free-running counter: advances on each step strobe and flags the wrap
// from all-ones to zero in the same cycle as that step.
module mft_freerun #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Counter register, cleared by reset or watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (step)     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign wrap  = step && (&cnt_q);
    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> count == $past(count) + CNT_W'(1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(count)); // R2
endmodule

// File: rtl/mft_cop.sv
// Watchdog counter: counts periodic ticks and fires on the tick that would
// wrap it. A service strobe restarts it and beats a coincident tick.
module mft_cop #(
    parameter int COP_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic service,
    output logic fire
);
    logic [COP_W-1:0] cop_q;

    assign fire = tick && !service && (&cop_q);

    // Tick counter; restart on reset, service or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || service || fire) cop_q <= '0;
        else if (tick)                 cop_q <= cop_q + COP_W'(1);
    end

    AST_SVC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> cop_q == '0); // R9
    AST_COP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !service && !fire) |=> cop_q == $past(cop_q) + COP_W'(1)); // R8
endmodule

// File: rtl/mft_timer_wdog.sv
// Top: status register, flag set/clear rules, interrupt gating and the
// watchdog reset pulse. On expiry every state element returns to its reset
// value in the same edge that raises wdr_o for one cycle.
module mft_timer_wdog
    import mft_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int CNT_DIV_LOG2 = 2,
    parameter int RTI_DIV_LOG2 = 11,
    parameter int COP_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       csr_rd,
    output logic [CNT_W-1:0] cnt_rd,
    output logic             irq_o,
    output logic             wdr_o
);
    csr_t csr_q;
    logic cnt_tick, rti_tick, wrap, fire, wdr_q;
    logic csr_wr, svc_wr;
    logic unused_rsvd;

    assign csr_wr      = wr_en && (wr_sel == SEL_CSR);
    assign svc_wr      = wr_en && (wr_sel == SEL_SVC);
    assign unused_rsvd = ^wr_data[3:2];

    mft_prescaler #(.CNT_DIV_LOG2(CNT_DIV_LOG2), .RTI_DIV_LOG2(RTI_DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(fire), .rate(csr_q.rate),
        .cnt_tick(cnt_tick), .rti_tick(rti_tick));

    mft_freerun #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(fire), .step(cnt_tick),
        .count(cnt_rd), .wrap(wrap));

    mft_cop #(.COP_W(COP_W)) u_cop (
        .clk(clk), .rst_n(rst_n), .tick(rti_tick), .service(svc_wr),
        .fire(fire));

    // Status register: flags set by events, cleared by written zeros; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || fire) begin
            csr_q <= CSR_RESET;
        end else begin
            csr_q.ovf_flag <= wrap |
                (csr_q.ovf_flag & ~(csr_wr & ~wr_data[BIT_OVF]));
            csr_q.per_flag <= rti_tick |
                (csr_q.per_flag & ~(csr_wr & ~wr_data[BIT_PER]));
            if (csr_wr) begin
                csr_q.ovf_en <= wr_data[BIT_OVF_EN];
                csr_q.per_en <= wr_data[BIT_PER_EN];
                csr_q.rate   <= wr_data[1:0];
            end
        end
    end

    // Watchdog reset pulse, one cycle after the expiry tick.
    always_ff @(posedge clk) begin
        if (!rst_n) wdr_q <= 1'b0;
        else        wdr_q <= fire;
    end

    assign csr_rd = {csr_q.ovf_flag, csr_q.per_flag, csr_q.ovf_en,
                     csr_q.per_en, 2'b00, csr_q.rate};
    assign irq_o  = (csr_q.ovf_flag & csr_q.ovf_en) |
                    (csr_q.per_flag & csr_q.per_en);
    assign wdr_o  = wdr_q;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !fire) |=> csr_rd[BIT_OVF]); // R3
    AST_PER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_tick && !fire) |=> csr_rd[BIT_PER]); // R4
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && wr_data[BIT_PER] && csr_rd[BIT_PER] && !fire) |=> csr_rd[BIT_PER]); // R5
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (csr_rd[BIT_OVF] || csr_rd[BIT_PER])); // R6
    AST_WDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdr_o |=> !wdr_o); // R8
    AST_WDR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        wdr_o |-> (csr_rd == 8'h03 && cnt_rd == '0)); // R8
endmodule

// File: tb/mft_timer_wdog_tb.sv
// Scoreboard bench: scenario tasks queue expected port values stamped with
// the cycle they are due in; a monitor compares them at the falling edge.
module mft_timer_wdog_tb;
    localparam int SIG_CSR = 0, SIG_CNT = 1, SIG_IRQ = 2, SIG_WDR = 3;

    typedef struct {
        int         at;
        int         sig;
        logic [7:0] val;
        string      req;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] csr_rd, cnt_rd;
    logic       irq_o, wdr_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    mft_timer_wdog #(.CNT_W(8), .CNT_DIV_LOG2(2), .RTI_DIV_LOG2(4), .COP_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .csr_rd(csr_rd), .cnt_rd(cnt_rd),
        .irq_o(irq_o), .wdr_o(wdr_o));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor: pop every item that has come due and compare it with the port.
    always @(negedge clk) begin : mon
        sb_item_t it;
        logic [7:0] act;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            it = sb_q.pop_front();
            case (it.sig)
                SIG_CSR: act = csr_rd;
                SIG_CNT: act = cnt_rd;
                SIG_IRQ: act = {7'd0, irq_o};
                default: act = {7'd0, wdr_o};
            endcase
            n_chk++;
            if (act !== it.val) begin
                n_bad++;
                $display("FAIL %s cycle %0d sig %0d: actual %02h expected %02h",
                         it.req, cyc, it.sig, act, it.val);
            end
        end
    end

    task automatic expect_at(input int at, input int sig, input logic [7:0] v,
                             input string req);
        sb_item_t it;
        it.at = at; it.sig = sig; it.val = v; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic write_at(input int at, input logic sel, input logic [7:0] d);
        while (cyc < at) @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        // Scenario A: defaults, slowest rate (tick every 128 clocks).
        do_reset();
        expect_at(0, SIG_CSR, 8'h03, "R1");
        expect_at(0, SIG_CNT, 8'h00, "R1");
        expect_at(0, SIG_IRQ, 8'h00, "R1");
        expect_at(0, SIG_WDR, 8'h00, "R1");
        expect_at(40, SIG_CNT, 8'd10, "R2");
        expect_at(43, SIG_CNT, 8'd10, "R2");
        expect_at(44, SIG_CNT, 8'd11, "R2");
        expect_at(127, SIG_CSR, 8'h03, "R4");
        expect_at(128, SIG_CSR, 8'h43, "R4");
        expect_at(1023, SIG_CSR, 8'h43, "R3");
        expect_at(1024, SIG_CSR, 8'hC3, "R3");
        expect_at(1024, SIG_CNT, 8'h00, "R3");
        expect_at(1024, SIG_IRQ, 8'h00, "R6");
        expect_at(8191, SIG_WDR, 8'h00, "R8");
        expect_at(8192, SIG_WDR, 8'h01, "R8");
        expect_at(8192, SIG_CSR, 8'h03, "R8");
        expect_at(8193, SIG_WDR, 8'h00, "R8");
        drain();

        // Scenario B: rate 00 (tick every 16), enables and write rules.
        do_reset();
        expect_at(15, SIG_CSR, 8'h30, "R7");
        expect_at(16, SIG_CSR, 8'h70, "R4");
        expect_at(16, SIG_IRQ, 8'h01, "R6");
        expect_at(21, SIG_CSR, 8'h30, "R5");
        expect_at(21, SIG_IRQ, 8'h00, "R5");
        expect_at(32, SIG_CSR, 8'h70, "R4");
        expect_at(41, SIG_CSR, 8'h70, "R5");
        expect_at(51, SIG_CSR, 8'h60, "R7");
        expect_at(51, SIG_IRQ, 8'h00, "R6");
        expect_at(1023, SIG_WDR, 8'h00, "R8");
        expect_at(1024, SIG_WDR, 8'h01, "R8");
        expect_at(1024, SIG_CSR, 8'h03, "R8");
        expect_at(1024, SIG_CNT, 8'h00, "R8");
        write_at(0, 1'b0, 8'h30);
        write_at(20, 1'b0, 8'h30);
        write_at(40, 1'b0, 8'hF0);
        write_at(50, 1'b0, 8'h6C);
        drain();

        // Scenario C: service writes, overflow interrupt, set beats clear.
        do_reset();
        expect_at(1024, SIG_CSR, 8'hC0, "R3");
        expect_at(1024, SIG_IRQ, 8'h00, "R6");
        expect_at(1031, SIG_CSR, 8'hA0, "R5");
        expect_at(1031, SIG_IRQ, 8'h01, "R6");
        expect_at(1039, SIG_CSR, 8'hA0, "R5");
        expect_at(1040, SIG_CSR, 8'h60, "R5");
        expect_at(1040, SIG_IRQ, 8'h00, "R6");
        expect_at(2016, SIG_WDR, 8'h00, "R9");
        expect_at(2031, SIG_WDR, 8'h00, "R9");
        expect_at(2032, SIG_WDR, 8'h01, "R9");
        expect_at(2032, SIG_CSR, 8'h03, "R8");
        write_at(0, 1'b0, 8'h00);
        write_at(1000, 1'b1, 8'h00);
        write_at(1007, 1'b1, 8'h00);
        write_at(1030, 1'b0, 8'hA0);
        write_at(1039, 1'b0, 8'h20);
        drain();

        // Scenario D: rate 01 (tick every 32, timeout at 2048).
        do_reset();
        expect_at(31, SIG_CSR, 8'h01, "R4");
        expect_at(32, SIG_CSR, 8'h41, "R4");
        expect_at(2047, SIG_CSR, 8'hC1, "R3");
        expect_at(2047, SIG_WDR, 8'h00, "R8");
        expect_at(2048, SIG_WDR, 8'h01, "R8");
        expect_at(2048, SIG_CSR, 8'h03, "R8");
        write_at(0, 1'b0, 8'h01);
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog on the bench itself.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule